// File: doc/BRIEF.md
# Condition Flag Register and Branch Resolver

This block keeps the three status flags of a 16-bit datapath: negative, zero and positive. Each time a result is written to the shared data bus, control may ask the block to classify that value and store the outcome. The flags are then the basis on which conditional branches are resolved. Only one flag is ever set, and it describes the last value that was captured.

The block also decides whether a conditional branch is taken. The decoded instruction supplies a three-bit condition mask, one bit per flag. When the current opcode is the branch opcode and any masked flag is set, the taken output goes high. That output selects the address-adder path at the program counter multiplexer. Address arithmetic itself is done elsewhere.

A capture needs two things in the same clock edge: the load strobe from control, and an opcode that belongs to the flag-writing group. If either is missing, the stored flags stay as they are.

Top module: `cc_branch_unit`

## Requirements
- R1: An asynchronous active-low reset leaves the zero flag set and the negative and positive flags clear.
- R2: After a capture of a bus value whose bit 15 is 1, only the negative flag is set.
- R3: After a capture of an all-zero bus value, only the zero flag is set.
- R4: After a capture of a nonzero bus value whose bit 15 is 0, only the positive flag is set.
- R5: Exactly one of the three flags is set in every cycle.
- R6: A capture takes effect at the rising clock edge where `cc_load` is high, and the new flags are visible in the cycle after that edge.
- R7: Only opcodes 4'b0001, 4'b0101, 4'b1001, 4'b0010, 4'b1010, 4'b0110 and 4'b1110 write the flags. Any other opcode presented with `cc_load` high leaves the flags unchanged.
- R8: A flag-writing opcode with `cc_load` low leaves the flags unchanged.
- R9: `br_taken` is combinational. It equals (mask[2] AND N) OR (mask[1] AND Z) OR (mask[0] AND P) while the opcode is 4'b0000.
- R10: `br_taken` is low for every opcode other than 4'b0000, whatever the mask and flags are.
- R11: With opcode 4'b0000, a mask of 3'b000 is never taken and a mask of 3'b111 is always taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_val | input | 16 | Value currently on the shared data bus |
| cc_load | input | 1 | Flag capture strobe from control |
| opcode | input | 4 | Opcode field of the current instruction |
| br_mask | input | 3 | Branch condition mask: bit 2 tests N, bit 1 tests Z, bit 0 tests P |
| flag_n | output | 1 | Last captured value was negative |
| flag_z | output | 1 | Last captured value was zero |
| flag_p | output | 1 | Last captured value was positive |
| br_taken | output | 1 | Branch condition met; selects the branch target for the PC |

## Verification
The bench targets the classification edges: 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF. A design that tests signedness on the wrong bit, or that treats zero as positive, would report the wrong flag for one of these. It also presents a flag-writing opcode with the strobe low, and non-writing opcodes with the strobe high. A design that ignores either gate would overwrite flags that must be held. Finally, every non-branch opcode is paired with a full mask, and the empty and full masks are tried on the branch opcode. This catches a resolver that does not decode the opcode, or that maps the mask bits to the wrong flags.

// File: rtl/cc_pkg.sv
package cc_pkg;
    parameter int DATA_W = 16;
    parameter int OPC_W  = 4;

    localparam logic [OPC_W-1:0] OPC_BRANCH   = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_SUM      = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_BITAND   = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_INVERT   = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_LD_REL   = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_LD_IND   = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_LD_BASE  = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_ADDR_GEN = 4'b1110;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    typedef struct packed {
        flags_t flags;
    } cc_state_t;
endpackage

// File: rtl/cc_value_classify.sv
module cc_value_classify
    import cc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] value,
    output flags_t       cls
);
    localparam int SIGN_BIT = W - 1;

    always_comb begin
        cls.n = value[SIGN_BIT];
        cls.z = (value == '0);
        cls.p = !value[SIGN_BIT] && (value != '0);
    end

    always_comb begin
        assert ($countones({cls.n, cls.z, cls.p}) == 1 || $isunknown(value))
            else $error("AST_CLASS_ONEHOT"); // R5
    end
endmodule

// File: rtl/cc_opcode_filter.sv
module cc_opcode_filter
    import cc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             writes_flags
);
    always_comb begin
        unique case (opcode)
            OPC_SUM, OPC_BITAND, OPC_INVERT,
            OPC_LD_REL, OPC_LD_IND, OPC_LD_BASE,
            OPC_ADDR_GEN: writes_flags = 1'b1;
            default:      writes_flags = 1'b0;
        endcase
    end
endmodule

// File: rtl/cc_branch_resolve.sv
module cc_branch_resolve
    import cc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [2:0]       mask,
    input  flags_t           flags,
    output logic             taken
);
    logic is_branch;
    logic [2:0] hits;

    always_comb begin
        is_branch = (opcode == OPC_BRANCH);
        hits      = mask & {flags.n, flags.z, flags.p};
        taken     = is_branch && (hits != 3'b000);
    end

    always_comb begin
        if (!is_branch) begin
            assert (!taken) else $error("AST_TAKEN_NEEDS_BRANCH"); // R10
        end
    end
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_val,
    input  logic              cc_load,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [2:0]        br_mask,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_p,
    output logic              br_taken
);
    cc_state_t state_d, state_q;
    flags_t    bus_cls;
    logic      op_writes;
    logic      capture;

    cc_value_classify #(.W(DATA_W)) i_classify (
        .value (bus_val),
        .cls   (bus_cls)
    );

    cc_opcode_filter i_filter (
        .opcode       (opcode),
        .writes_flags (op_writes)
    );

    cc_branch_resolve i_resolve (
        .opcode (opcode),
        .mask   (br_mask),
        .flags  (state_q.flags),
        .taken  (br_taken)
    );

    always_comb begin
        state_d = state_q;
        capture = cc_load && op_writes;
        if (capture) begin
            state_d.flags = bus_cls;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.flags <= FLAGS_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_n = state_q.flags.n;
    assign flag_z = state_q.flags.z;
    assign flag_p = state_q.flags.p;

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (flag_z && !flag_n && !flag_p)); // R1
    AST_NEG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_load && op_writes && bus_val[DATA_W-1]) |=> flag_n); // R2
    AST_ZERO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_load && op_writes && bus_val == '0) |=> flag_z); // R3
    AST_POS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_load && op_writes && !bus_val[DATA_W-1] && bus_val != '0) |=> flag_p); // R4
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flag_n, flag_z, flag_p}) == 1); // R5
    AST_NONWRITER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_load && !op_writes) |=> $stable({flag_n, flag_z, flag_p})); // R7
    AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_load |=> $stable({flag_n, flag_z, flag_p})); // R8
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_BRANCH && br_mask == 3'b111) |-> br_taken); // R11
endmodule

// File: tb/test_cc_branch_unit.sv
module test_cc_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_val = '0;
    logic        cc_load = 1'b0;
    logic [3:0]  opcode = 4'b1111;
    logic [2:0]  br_mask = 3'b000;
    logic        flag_n, flag_z, flag_p, br_taken;

    int checks = 0;
    int failures = 0;

    cc_branch_unit i_cc_branch_unit (
        .clk(clk), .rst_n(rst_n), .bus_val(bus_val), .cc_load(cc_load),
        .opcode(opcode), .br_mask(br_mask), .flag_n(flag_n), .flag_z(flag_z),
        .flag_p(flag_p), .br_taken(br_taken)
    );

    always #5 clk = ~clk;

    // {opcode, load, bus, expected nzp, mask, expected taken}
    localparam int NV = 13;
    localparam logic [27:0] VEC [NV] = '{
        {4'b0001, 1'b1, 16'h8000, 3'b100, 3'b100, 1'b1}, // R2 R6 R9
        {4'b0101, 1'b1, 16'h0000, 3'b010, 3'b101, 1'b0}, // R3 R9
        {4'b1001, 1'b1, 16'h0001, 3'b001, 3'b001, 1'b1}, // R4 R9
        {4'b0010, 1'b1, 16'h7FFF, 3'b001, 3'b110, 1'b0}, // R4 R9
        {4'b1010, 1'b1, 16'hFFFF, 3'b100, 3'b011, 1'b0}, // R2 R9
        {4'b0110, 1'b1, 16'h0000, 3'b010, 3'b010, 1'b1}, // R3 R9
        {4'b1110, 1'b1, 16'h1234, 3'b001, 3'b111, 1'b1}, // R4 R11
        {4'b0001, 1'b0, 16'h8000, 3'b001, 3'b100, 1'b0}, // R8
        {4'b0011, 1'b1, 16'h0000, 3'b001, 3'b001, 1'b1}, // R7
        {4'b0000, 1'b1, 16'h8000, 3'b001, 3'b000, 1'b0}, // R7 R11
        {4'b1100, 1'b1, 16'hFFFF, 3'b001, 3'b001, 1'b1}, // R7
        {4'b1101, 1'b1, 16'h0000, 3'b001, 3'b110, 1'b0}, // R7
        {4'b0001, 1'b1, 16'h0000, 3'b010, 3'b111, 1'b1}  // R3 R11
    };

    task automatic check_bits(input logic [2:0] act, input logic [2:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [27:0] v, input int idx);
        @(negedge clk);
        opcode  = v[27:24];
        cc_load = v[23];
        bus_val = v[22:7];
        @(negedge clk);
        cc_load = 1'b0;
        check_bits({flag_n, flag_z, flag_p}, v[6:4], $sformatf("R6 flags vec%0d", idx));
        check_bits({2'b00, ($countones({flag_n, flag_z, flag_p}) == 1)}, 3'b001, "R5 one flag");
        opcode  = 4'b0000;
        br_mask = v[3:1];
        #1;
        check_bits({2'b00, br_taken}, {2'b00, v[0]}, $sformatf("R9 taken vec%0d", idx));
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #12;
        check_bits({flag_n, flag_z, flag_p}, 3'b010, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        opcode = 4'b0000;
        br_mask = 3'b010;
        #1;
        check_bits({2'b00, br_taken}, 3'b001, "R1 zero after reset taken");

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R10: every non-branch opcode with full mask (flags Z set now)
        for (int op = 1; op < 16; op++) begin
            @(negedge clk);
            cc_load = 1'b0;
            opcode  = 4'(op);
            br_mask = 3'b111;
            #1;
            check_bits({2'b00, br_taken}, 3'b000, $sformatf("R10 opcode %0d", op));
        end

        // R11: empty mask never taken under each flag state
        @(negedge clk);
        opcode = 4'b0001; cc_load = 1'b1; bus_val = 16'h8000;
        @(negedge clk);
        cc_load = 1'b0; opcode = 4'b0000; br_mask = 3'b000;
        #1;
        check_bits({2'b00, br_taken}, 3'b000, "R11 empty mask with N");
        br_mask = 3'b011;
        #1;
        check_bits({2'b00, br_taken}, 3'b000, "R9 mask ZP with N");

        // R1: reset in mid-run returns to Z
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_bits({flag_n, flag_z, flag_p}, 3'b010, "R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule